// File: doc/BRIEF.md
# Power-on request arbitration controller

This block decides when a power management device leaves its idle states. Several wake sources feed it as already-conditioned digital levels: the button or enable input, first-supply detection, two real-time-clock events, wake pins, low-power wake pins, and recovery after a shutdown. Each source has its own mask bit. Supply and thermal fault flags come in as digital inputs, and no mask can override them. While any fault flag is active, no request is accepted.

An accepted request moves the sequencer from standby or low-power standby into a destination-wait state. The sequencer records which source caused the wake, latches a 2-bit destination code from configuration, and raises a startup interrupt. It stays parked there until software clears the interrupt with a one-cycle pulse. It then moves to a run-selection state, where the two sleep control inputs choose what happens next. A thermal shutdown flag sends the sequencer to a safe-recovery state from any state. It stays there until the temperature has come back down.

Top module: `pwr_wake_arbiter`

## Requirements
- R1: After synchronous reset, `state_o` is 0 (standby), `startup_irq_o` is 0, and `dest_o`, `wake_src_o` and `run_mode_o` are 0.
- R2: State codes are 0 standby, 1 low-power standby, 2 safe recovery, 3 destination wait and 4 run selection. When an unmasked request is present in state 0 with no fault, the next clock edge sets `state_o` to 3 and `startup_irq_o` to 1. `dest_o` then shows the value of `dest_cfg_i` sampled on that edge, and it shows that value only while the state is 3.
- R3: A source whose bit in `src_mask_i` is 1 is ignored.
- R4: `wake_src_o` takes the index of the source that caused the wake on the accepting edge. Bit i of `src_req_i` is source i. When several unmasked sources are active together, the lowest index wins.
- R5: The first-supply source is bit 1. It counts as a request only while `supply_good_i` is 1.
- R6: No request is accepted while any of these is true: `vin_ov_i` together with `ov_lock_en_i`, `vin_uvlo_i`, `vint_ov_i`, `vint_uv_i`, or `tsd_i`. `vin_ov_i` has no effect while `ov_lock_en_i` is 0.
- R7: When `tsd_i` is 1, the next edge sets the state to 2 from any state and clears the interrupt. The state stays 2 until `tsd_i` is 0 and `temp_ok_i` is 1 on the same edge, and then goes to 0.
- R8: In state 3, the state and the interrupt hold until a clear pulse arrives. New requests have no effect there.
- R9: A 1 on `irq_clr_i` in state 3 sets the state to 4 and the interrupt to 0 on the next edge. A 1 on `irq_clr_i` in any other state has no effect.
- R10: In state 4, `run_mode_o` follows `sleep_i`. A `sleep_i` value of 0 moves the state to 1 on the next edge, and any other value keeps the state at 4. A request is accepted from state 1 in the same way as from state 0.
- R11: Requests have no effect in states 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req_i | input | NUM_SRC | Wake request levels, one bit per source |
| src_mask_i | input | NUM_SRC | Per-source mask, 1 ignores the source |
| supply_good_i | input | 1 | Supply above undervoltage threshold, qualifies first-supply source |
| vin_ov_i | input | 1 | Input over-voltage flag |
| ov_lock_en_i | input | 1 | Makes input over-voltage a blocking condition |
| vin_uvlo_i | input | 1 | Input under-voltage lockout flag |
| vint_ov_i | input | 1 | Internal rail over-voltage flag |
| vint_uv_i | input | 1 | Internal rail under-voltage flag |
| tsd_i | input | 1 | Thermal shutdown flag |
| temp_ok_i | input | 1 | Temperature below warning level |
| dest_cfg_i | input | 2 | Destination code latched on wake |
| irq_clr_i | input | 1 | Single-cycle interrupt clear pulse |
| sleep_i | input | 2 | Sleep control inputs |
| state_o | output | 3 | Sequencer state code |
| dest_o | output | 2 | Latched destination code, nonzero only in state 3 |
| startup_irq_o | output | 1 | Startup interrupt flag |
| wake_src_o | output | IDX_W | Index of the source that caused the last wake |
| run_mode_o | output | 2 | Sleep inputs passed through in state 4, else 0 |

## Verification
The bench builds the block with its defaults: seven sources and the first-supply source at index 1. With these values the highest index, 6, can be reached, so a test can check that a high source wins only when every lower one is absent or masked. Each fault flag can be driven alone, so each one is shown to block a request. The first-supply qualifier sits on its own bit, so it can be tested with no other source present.

// File: rtl/pwr_wake_pkg.sv
package pwr_wake_pkg;

    localparam int MAX_SRC = 16;

    typedef enum logic [2:0] {
        ST_STBY   = 3'd0,
        ST_LPSTBY = 3'd1,
        ST_SAFE   = 3'd2,
        ST_DEST   = 3'd3,
        ST_SEL    = 3'd4
    } wake_state_e;

    typedef struct packed {
        logic       accept;
        logic [3:0] idx;
    } wake_pick_t;

    // lowest set bit index of a vector padded to MAX_SRC
    function automatic logic [3:0] first_set(input logic [MAX_SRC-1:0] v);
        logic [3:0] r;
        r = '0;
        for (int i = MAX_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = 4'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/wake_fault_gate.sv
module wake_fault_gate (
    input  logic vin_ov_i,
    input  logic ov_lock_en_i,
    input  logic vin_uvlo_i,
    input  logic vint_ov_i,
    input  logic vint_uv_i,
    input  logic tsd_i,
    output logic block_o
);
    assign block_o = (vin_ov_i & ov_lock_en_i) | vin_uvlo_i | vint_ov_i
                   | vint_uv_i | tsd_i;
endmodule

// File: rtl/wake_src_gate.sv
module wake_src_gate
    import pwr_wake_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter int FSD_IDX = 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic               supply_good_i,
    input  logic               block_i,
    output wake_pick_t         pick_o
);
    logic [NUM_SRC-1:0] live;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_qual
        if (g == FSD_IDX) begin : g_fsd
            assign live[g] = req_i[g] & ~mask_i[g] & supply_good_i;
        end else begin : g_plain
            assign live[g] = req_i[g] & ~mask_i[g];
        end
    end

    assign pick_o.accept = (|live) & ~block_i;
    assign pick_o.idx    = first_set(MAX_SRC'(live));

    // R6: a blocking fault never lets a pick through
    p_fault_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        block_i |-> !pick_o.accept);

    // R3: a fully masked request set never yields a pick
    p_mask_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        ((req_i & ~mask_i) == '0) |-> !pick_o.accept);
endmodule

// File: rtl/wake_seq_fsm.sv
module wake_seq_fsm
    import pwr_wake_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int DEST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  wake_pick_t        pick_i,
    input  logic              tsd_i,
    input  logic              temp_ok_i,
    input  logic [DEST_W-1:0] dest_cfg_i,
    input  logic              irq_clr_i,
    input  logic [1:0]        sleep_i,
    output wake_state_e       state_o,
    output logic [DEST_W-1:0] dest_o,
    output logic              irq_o,
    output logic [IDX_W-1:0]  src_o,
    output logic [1:0]        run_mode_o
);
    wake_state_e       state_q, state_d;
    logic [DEST_W-1:0] dest_q;
    logic [IDX_W-1:0]  src_q;
    logic              irq_q;
    logic              idle, take;

    assign idle = (state_q == ST_STBY) || (state_q == ST_LPSTBY);
    assign take = idle && pick_i.accept;

    always_comb begin
        state_d = state_q;
        if (tsd_i) begin
            state_d = ST_SAFE;
        end else begin
            unique case (state_q)
                ST_STBY, ST_LPSTBY: if (take) state_d = ST_DEST;
                ST_SAFE:            if (temp_ok_i) state_d = ST_STBY;
                ST_DEST:            if (irq_clr_i) state_d = ST_SEL;
                ST_SEL:             if (sleep_i == 2'b00) state_d = ST_LPSTBY;
                default:            state_d = ST_STBY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_STBY;
            dest_q  <= '0;
            src_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take && !tsd_i) begin
                dest_q <= dest_cfg_i;
                src_q  <= IDX_W'(pick_i.idx);
            end
            if (state_d == ST_DEST && state_q != ST_DEST) irq_q <= 1'b1;
            else if (state_d != ST_DEST)                  irq_q <= 1'b0;
        end
    end

    assign state_o    = state_q;
    assign dest_o     = (state_q == ST_DEST) ? dest_q : '0;
    assign irq_o      = irq_q;
    assign src_o      = src_q;
    assign run_mode_o = (state_q == ST_SEL) ? sleep_i : 2'b00;

    // R2: destination wait is only entered from an idle state
    p_entry_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DEST && $past(state_q) != ST_DEST)
            |-> ($past(state_q) == ST_STBY || $past(state_q) == ST_LPSTBY));

    // R8: interrupt flag only lives in destination wait
    p_irq_in_dest_r8: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> state_q == ST_DEST);

    // R7: thermal shutdown forces safe recovery
    p_tsd_safe_r7: assert property (@(posedge clk) disable iff (rst)
        tsd_i |=> state_q == ST_SAFE);

    // R9: a clear pulse outside destination wait never produces run selection
    p_clr_outside_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_DEST && state_q != ST_SEL && irq_clr_i)
            |=> state_q != ST_SEL);

    // R11: no wake from safe recovery or run selection
    p_no_wake_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SAFE || state_q == ST_SEL) |=> state_q != ST_DEST);
endmodule

// File: rtl/pwr_wake_arbiter.sv
module pwr_wake_arbiter
    import pwr_wake_pkg::*;
#(
    parameter int NUM_SRC = 7,
    parameter int FSD_IDX = 1,
    parameter int DEST_W  = 2,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic [NUM_SRC-1:0] src_mask_i,
    input  logic               supply_good_i,
    input  logic               vin_ov_i,
    input  logic               ov_lock_en_i,
    input  logic               vin_uvlo_i,
    input  logic               vint_ov_i,
    input  logic               vint_uv_i,
    input  logic               tsd_i,
    input  logic               temp_ok_i,
    input  logic [DEST_W-1:0]  dest_cfg_i,
    input  logic               irq_clr_i,
    input  logic [1:0]         sleep_i,
    output logic [2:0]         state_o,
    output logic [DEST_W-1:0]  dest_o,
    output logic               startup_irq_o,
    output logic [IDX_W-1:0]   wake_src_o,
    output logic [1:0]         run_mode_o
);
    logic        blk;
    wake_pick_t  pick;
    wake_state_e st;

    wake_fault_gate u_fault (
        .vin_ov_i    (vin_ov_i),
        .ov_lock_en_i(ov_lock_en_i),
        .vin_uvlo_i  (vin_uvlo_i),
        .vint_ov_i   (vint_ov_i),
        .vint_uv_i   (vint_uv_i),
        .tsd_i       (tsd_i),
        .block_o     (blk)
    );

    wake_src_gate #(.NUM_SRC(NUM_SRC), .FSD_IDX(FSD_IDX)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .req_i        (src_req_i),
        .mask_i       (src_mask_i),
        .supply_good_i(supply_good_i),
        .block_i      (blk),
        .pick_o       (pick)
    );

    wake_seq_fsm #(.IDX_W(IDX_W), .DEST_W(DEST_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .pick_i    (pick),
        .tsd_i     (tsd_i),
        .temp_ok_i (temp_ok_i),
        .dest_cfg_i(dest_cfg_i),
        .irq_clr_i (irq_clr_i),
        .sleep_i   (sleep_i),
        .state_o   (st),
        .dest_o    (dest_o),
        .irq_o     (startup_irq_o),
        .src_o     (wake_src_o),
        .run_mode_o(run_mode_o)
    );

    assign state_o = st;
endmodule

// File: tb/pwr_wake_arbiter_tb.sv
module pwr_wake_arbiter_tb_top;
    localparam int NS = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] req = '0, msk = '0;
    logic          sg = 1'b0, vov = 1'b0, lk = 1'b0, uvlo = 1'b0, iov = 1'b0, iuv = 1'b0;
    logic          tsd = 1'b0, tok = 1'b0, clr = 1'b0;
    logic [1:0]    dcfg = '0, slp = '0;
    logic [2:0]    st;
    logic [1:0]    dst, rmode;
    logic          irq;
    logic [2:0]    wsrc;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    pwr_wake_arbiter dut_i (
        .clk(clk), .rst(rst), .src_req_i(req), .src_mask_i(msk),
        .supply_good_i(sg), .vin_ov_i(vov), .ov_lock_en_i(lk),
        .vin_uvlo_i(uvlo), .vint_ov_i(iov), .vint_uv_i(iuv),
        .tsd_i(tsd), .temp_ok_i(tok), .dest_cfg_i(dcfg), .irq_clr_i(clr),
        .sleep_i(slp), .state_o(st), .dest_o(dst), .startup_irq_o(irq),
        .wake_src_o(wsrc), .run_mode_o(rmode)
    );

    // {req, mask, supply_good, vin_ov, lock, uvlo, vint_ov, vint_uv, exp_state, exp_src}
    localparam int VW = 7 + 7 + 1 + 5 + 3 + 3;
    localparam logic [VW-1:0] VEC [11] = '{
        {7'b0000001, 7'b0000000, 1'b0, 5'b00000, 3'd3, 3'd0},  // R2
        {7'b0000001, 7'b0000001, 1'b0, 5'b00000, 3'd0, 3'd0},  // R3
        {7'b1010100, 7'b0000000, 1'b0, 5'b00000, 3'd3, 3'd2},  // R4
        {7'b0000010, 7'b0000000, 1'b0, 5'b00000, 3'd0, 3'd0},  // R5 no supply
        {7'b0000010, 7'b0000000, 1'b1, 5'b00000, 3'd3, 3'd1},  // R5 supply good
        {7'b1000000, 7'b0000000, 1'b0, 5'b10000, 3'd3, 3'd6},  // R6 ov w/o lock
        {7'b1000000, 7'b0000000, 1'b0, 5'b11000, 3'd0, 3'd0},  // R6 ov + lock
        {7'b1000000, 7'b0000000, 1'b0, 5'b00100, 3'd0, 3'd0},  // R6 uvlo
        {7'b1000000, 7'b0000000, 1'b0, 5'b00010, 3'd0, 3'd0},  // R6 vint ov
        {7'b1000000, 7'b0000000, 1'b0, 5'b00001, 3'd0, 3'd0},  // R6 vint uv
        {7'b0001001, 7'b0000001, 1'b0, 5'b00000, 3'd3, 3'd3}   // R3/R4 masked low
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        req = '0; msk = '0; sg = 0; vov = 0; lk = 0; uvlo = 0; iov = 0; iuv = 0;
        tsd = 0; tok = 0; clr = 0; dcfg = '0; slp = '0;
    endtask

    task automatic do_reset();
        quiet();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;
    endtask

    initial begin
        #(5 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        chk("R1 state", st, 0);
        chk("R1 irq", irq, 0);
        chk("R1 dest", dst, 0);
        chk("R1 src", wsrc, 0);
        chk("R1 run", rmode, 0);

        for (int v = 0; v < 11; v++) begin
            do_reset();
            {req, msk, sg, vov, lk, uvlo, iov, iuv} = VEC[v][VW-1:6];
            step();
            chk($sformatf("R2-6 vec%0d state", v), st, int'(VEC[v][5:3]));
            if (VEC[v][5:3] == 3'd3)
                chk($sformatf("R4 vec%0d src", v), wsrc, int'(VEC[v][2:0]));
        end

        // R9: clear while in standby does nothing
        do_reset();
        clr = 1; step(); clr = 0;
        chk("R9 clr idle", st, 0);

        // R2 destination code, R8 hold
        dcfg = 2'b10; req = 7'b0100000; step();
        chk("R2 state", st, 3);
        chk("R2 dest", dst, 2);
        chk("R2 irq", irq, 1);
        dcfg = 2'b01; req = 7'b0000001; step(); step();
        chk("R8 hold state", st, 3);
        chk("R8 hold irq", irq, 1);
        chk("R8 src kept", wsrc, 5);
        chk("R8 dest kept", dst, 2);

        // R9 clear in destination wait
        req = '0; slp = 2'b01; clr = 1; step(); clr = 0;
        chk("R9 state", st, 4);
        chk("R9 irq", irq, 0);
        chk("R2 dest outside", dst, 0);
        chk("R10 run mode", rmode, 1);
        // R11: request in run selection ignored
        req = 7'b0000001; step();
        chk("R11 sel", st, 4);
        req = '0; slp = 2'b00; step();
        chk("R10 lp", st, 1);
        chk("R10 run idle", rmode, 0);
        req = 7'b0001000; step();
        chk("R10 wake lp", st, 3);
        chk("R10 src", wsrc, 3);

        // R7 thermal
        req = '0; tsd = 1; step();
        chk("R7 safe", st, 2);
        chk("R7 irq", irq, 0);
        tsd = 0; tok = 0; req = 7'b0000001; step();
        chk("R11 safe", st, 2);
        req = '0; tok = 1; step();
        chk("R7 exit", st, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule